// File: doc/BRIEF.md
# Configurable Serial Frame Transmitter

This block turns characters of five to nine data bits into asynchronous serial frames on a single output line. Each frame opens with a low start bit, carries the data bits least significant first, may add an even or odd parity bit, and closes with one or two high stop bits. The size, parity and stop options are inputs that are captured when a character enters the shift register, so they can be changed between frames without harm.

A one-entry holding buffer sits in front of the shift register. The ninth data bit arrives on its own input and is captured with the low byte in the same write. An external baud generator supplies a one-cycle bit tick, and every tick moves the line on by one bit time. Two flags report state: one shows that the holding buffer can take a character, and the other shows that the line has drained with nothing left to send. Each flag drives an interrupt request through its own enable. The done flag is cleared by a write-one pulse or by an interrupt acknowledge.

Top module: `uart_frame_tx`

## Requirements
- R1: Once a character has been loaded, the line holds the start bit (0) for one tick period. It then presents the data bits least significant first, then the parity bit if parity is enabled, then the stop bits (1). Each tick advances exactly one bit, and the line changes on no other cycle.
- R2: `char_size` selects the data width: code 0 gives 5 bits, 1 gives 6, 2 gives 7, 3 gives 8 and 4 gives 9. Codes 5 to 7 give 8 bits.
- R3: Data bits above the selected width are ignored. They are not sent and they do not enter the parity.
- R4: In 9-bit mode the ninth data bit is the value of `wr_bit8` sampled in the cycle of the accepted write.
- R5: With `par_en`=1 the parity bit is placed after the last data bit. With `par_odd`=0 it makes the count of ones in data plus parity even, and with `par_odd`=1 it makes that count odd.
- R6: `two_stop`=1 sends two stop bits and `two_stop`=0 sends one.
- R7: `buf_empty` is 1 after reset. It goes 0 on the edge that accepts a write, and it returns to 1 on the tick that moves the character into the idle shift register. A write made while `buf_empty` is 0 is discarded.
- R8: If a character is waiting when the last stop bit ends, its start bit begins on that same tick and `tx_done` stays 0.
- R9: `tx_done` sets on the tick that ends the last stop bit when no character is waiting. `txc_clr` or `txc_ack` clears it, and a set in the same cycle as a clear takes priority.
- R10: `irq_empty` equals `ie_empty` AND `buf_empty`, and `irq_done` equals `ie_done` AND `tx_done`.
- R11: While `tx_en` is 0 the line is held at 1 and no character leaves the buffer.
- R12: During and straight after reset, `tx_line` is 1 and `tx_done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_en | input | 1 | Transmitter enable |
| bit_tick | input | 1 | One-cycle bit-time strobe from the baud generator |
| char_size | input | 3 | Data width code |
| par_en | input | 1 | Parity enable |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| two_stop | input | 1 | 1 = two stop bits |
| wr_valid | input | 1 | Write strobe for the holding buffer |
| wr_data | input | 8 | Low eight data bits |
| wr_bit8 | input | 1 | Ninth data bit |
| txc_clr | input | 1 | Write-one clear of the done flag |
| txc_ack | input | 1 | Interrupt acknowledge for the done flag |
| ie_empty | input | 1 | Enable for the buffer-empty request |
| ie_done | input | 1 | Enable for the done request |
| tx_line | output | 1 | Serial output, idles high |
| buf_empty | output | 1 | Holding buffer can take a character |
| tx_done | output | 1 | Frame finished and nothing queued |
| irq_empty | output | 1 | Buffer-empty interrupt request |
| irq_done | output | 1 | Done interrupt request |

## Verification
Two pairs of events can fall in the same cycle. The first is the end of a frame together with the reload of a waiting character. The bench writes a second character just after the first frame loads, then checks that the closing tick already shows the new start bit and leaves `tx_done` low. The second is the setting of the done flag together with a software clear. The bench pulses `txc_clr` in the same cycle as the final tick and expects `tx_done` to read 1 afterwards. Every frame in the sweep over widths, parity modes and stop counts is compared bit by bit against a frame the bench computes arithmetically.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
    localparam int MAX_BITS = 9;
    localparam int FRAME_W  = 1 + MAX_BITS + 1 + 2;
    localparam int CNT_W    = $clog2(FRAME_W + 1);

    typedef struct packed {
        logic [MAX_BITS-1:0] data;
        logic                full;
    } hold_t;

    typedef struct packed {
        logic               busy;
        logic [FRAME_W-1:0] frame;
        logic [CNT_W-1:0]   cnt;
        logic [CNT_W-1:0]   len;
    } shift_t;

    function automatic logic [CNT_W-1:0] width_of(input logic [2:0] code);
        case (code)
            3'd0:    width_of = CNT_W'(5);
            3'd1:    width_of = CNT_W'(6);
            3'd2:    width_of = CNT_W'(7);
            3'd4:    width_of = CNT_W'(9);
            default: width_of = CNT_W'(8);
        endcase
    endfunction
endpackage

// File: rtl/uart_tx_holdbuf.sv
module uart_tx_holdbuf
    import uart_tx_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_valid,
    input  logic [MAX_BITS-1:0] wr_word,
    input  logic                take,
    output logic [MAX_BITS-1:0] data_o,
    output logic                full_o
);
    hold_t hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (take) begin
            hold_d.full = 1'b0;
        end else if (wr_valid && !hold_q.full) begin
            hold_d.data = wr_word;
            hold_d.full = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hold_q <= '0;
        else        hold_q <= hold_d;
    end

    assign data_o = hold_q.data;
    assign full_o = hold_q.full;
endmodule

// File: rtl/uart_tx_serializer.sv
module uart_tx_serializer
    import uart_tx_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tx_en,
    input  logic                bit_tick,
    input  logic [2:0]          char_size,
    input  logic                par_en,
    input  logic                par_odd,
    input  logic                two_stop,
    input  logic                buf_full,
    input  logic [MAX_BITS-1:0] buf_data,
    output logic                take_o,
    output logic                frame_end_o,
    output logic                tx_line_o
);
    shift_t sh_d, sh_q;

    logic [CNT_W-1:0]    nbits;
    logic [MAX_BITS-1:0] masked;
    logic                par_bit;
    logic [FRAME_W-1:0]  built;
    logic [CNT_W-1:0]    built_len;
    logic                advance, last;

    always_comb begin
        nbits   = width_of(char_size);
        masked  = buf_data & ((MAX_BITS'(1) << nbits) - MAX_BITS'(1));
        par_bit = (^masked) ^ par_odd;
        built   = '1;
        built[0] = 1'b0;
        for (int i = 0; i < MAX_BITS; i++) begin
            if (i < int'(nbits)) built[1 + i] = masked[i];
        end
        if (par_en) built[1 + int'(nbits)] = par_bit;
        built_len = CNT_W'(1) + nbits + CNT_W'(par_en) + (two_stop ? CNT_W'(2) : CNT_W'(1));

        advance     = tx_en && bit_tick;
        last        = sh_q.busy && (sh_q.cnt == sh_q.len - CNT_W'(1));
        take_o      = advance && buf_full && (!sh_q.busy || last);
        frame_end_o = advance && last;

        sh_d = sh_q;
        if (!tx_en) begin
            sh_d.busy = 1'b0;
        end else if (take_o) begin
            sh_d.busy  = 1'b1;
            sh_d.frame = built;
            sh_d.cnt   = '0;
            sh_d.len   = built_len;
        end else if (frame_end_o) begin
            sh_d.busy  = 1'b0;
        end else if (advance && sh_q.busy) begin
            sh_d.frame = {1'b1, sh_q.frame[FRAME_W-1:1]};
            sh_d.cnt   = sh_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q       <= '0;
            sh_q.frame <= '1;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign tx_line_o = !(tx_en && sh_q.busy) || sh_q.frame[0];
endmodule

// File: rtl/uart_tx_status.sv
module uart_tx_status (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_end,
    input  logic take,
    input  logic txc_clr,
    input  logic txc_ack,
    input  logic buf_full,
    input  logic ie_empty,
    input  logic ie_done,
    output logic buf_empty_o,
    output logic tx_done_o,
    output logic irq_empty_o,
    output logic irq_done_o
);
    logic done_d, done_q;

    always_comb begin
        done_d = done_q;
        if (frame_end && !take)      done_d = 1'b1;
        else if (txc_clr || txc_ack) done_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= done_d;
    end

    assign buf_empty_o = !buf_full;
    assign tx_done_o   = done_q;
    assign irq_empty_o = ie_empty && !buf_full;
    assign irq_done_o  = ie_done && done_q;
endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
    import uart_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tx_en,
    input  logic       bit_tick,
    input  logic [2:0] char_size,
    input  logic       par_en,
    input  logic       par_odd,
    input  logic       two_stop,
    input  logic       wr_valid,
    input  logic [7:0] wr_data,
    input  logic       wr_bit8,
    input  logic       txc_clr,
    input  logic       txc_ack,
    input  logic       ie_empty,
    input  logic       ie_done,
    output logic       tx_line,
    output logic       buf_empty,
    output logic       tx_done,
    output logic       irq_empty,
    output logic       irq_done
);
    logic [MAX_BITS-1:0] held_data;
    logic                held_full;
    logic                take;
    logic                frame_end;

    uart_tx_holdbuf u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_valid (wr_valid),
        .wr_word  ({wr_bit8, wr_data}),
        .take     (take),
        .data_o   (held_data),
        .full_o   (held_full)
    );

    uart_tx_serializer u_ser (
        .clk         (clk),
        .rst_n       (rst_n),
        .tx_en       (tx_en),
        .bit_tick    (bit_tick),
        .char_size   (char_size),
        .par_en      (par_en),
        .par_odd     (par_odd),
        .two_stop    (two_stop),
        .buf_full    (held_full),
        .buf_data    (held_data),
        .take_o      (take),
        .frame_end_o (frame_end),
        .tx_line_o   (tx_line)
    );

    uart_tx_status u_stat (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_end   (frame_end),
        .take        (take),
        .txc_clr     (txc_clr),
        .txc_ack     (txc_ack),
        .buf_full    (held_full),
        .ie_empty    (ie_empty),
        .ie_done     (ie_done),
        .buf_empty_o (buf_empty),
        .tx_done_o   (tx_done),
        .irq_empty_o (irq_empty),
        .irq_done_o  (irq_done)
    );
endmodule

// File: rtl/uart_frame_tx_chk.sv
module uart_frame_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic tx_en,
    input logic bit_tick,
    input logic wr_valid,
    input logic txc_clr,
    input logic txc_ack,
    input logic ie_done,
    input logic tx_line,
    input logic buf_empty,
    input logic tx_done,
    input logic irq_done
);
    // R11: disabled transmitter keeps the line high
    p_idle_high_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |-> tx_line);

    // R1: the line moves only on a bit tick while enabled
    p_move_on_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && $past(tx_en) && !$stable(tx_line)) |-> $past(bit_tick));

    // R7: the buffer fills only through a write
    p_fill_by_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(buf_empty) |-> $past(wr_valid));

    // R7: the buffer drains only on an enabled tick
    p_drain_on_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(buf_empty) |-> $past(bit_tick && tx_en));

    // R9: done rises only on a tick with nothing queued
    p_done_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_done) |-> ($past(bit_tick) && buf_empty && tx_line));

    // R9: done falls only by clear or acknowledge
    p_done_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_done) |-> $past(txc_clr || txc_ack));

    // R10: done request implies flag and enable
    p_irq_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_done |-> (tx_done && ie_done));
endmodule

bind uart_frame_tx uart_frame_tx_chk u_chk (.*);

// File: tb/uart_frame_tx_tb.sv
module uart_frame_tx_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_en = 1'b1;
    logic       bit_tick = 1'b0;
    logic [2:0] char_size = 3'd3;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic       two_stop = 1'b0;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = 8'd0;
    logic       wr_bit8 = 1'b0;
    logic       txc_clr = 1'b0;
    logic       txc_ack = 1'b0;
    logic       ie_empty = 1'b0;
    logic       ie_done = 1'b0;
    logic       tx_line, buf_empty, tx_done, irq_empty, irq_done;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    uart_frame_tx u_dut (.*);

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int nbits_of(input int code);
        return (code <= 4) ? code + 5 : 8;
    endfunction

    function automatic int frame_len();
        return 1 + nbits_of(int'(char_size)) + int'(par_en) + (two_stop ? 2 : 1);
    endfunction

    function automatic int frame_bit(input int d, input int k);
        int n = nbits_of(int'(char_size));
        int m = d & ((1 << n) - 1);
        int ones = 0;
        for (int i = 0; i < n; i++) ones += (m >> i) & 1;
        if (k == 0) return 0;
        if (k <= n) return (m >> (k - 1)) & 1;
        if (k == n + 1 && par_en) return (ones + int'(par_odd)) % 2;
        return 1;
    endfunction

    task automatic write_char(input int d);
        @(negedge clk);
        wr_valid = 1'b1; wr_data = d[7:0]; wr_bit8 = d[8];
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic tick(input logic clr);
        @(negedge clk);
        bit_tick = 1'b1; txc_clr = clr;
        @(negedge clk);
        bit_tick = 1'b0; txc_clr = 1'b0;
        @(negedge clk);
    endtask

    task automatic run_bits(input int d, input int from_k, input string req);
        for (int k = from_k; k < frame_len(); k++) begin
            tick(1'b0);
            chk(req, int'(tx_line), frame_bit(d, k));
        end
    endtask

    task automatic clear_done();
        @(negedge clk); txc_clr = 1'b1;
        @(negedge clk); txc_clr = 1'b0;
        chk("R9 clear by write-one", int'(tx_done), 0);
    endtask

    task automatic full_frame(input int d, input string req);
        write_char(d);
        chk("R7 full after write", int'(buf_empty), 0);
        tick(1'b0);
        chk("R1 start bit", int'(tx_line), 0);
        chk("R7 empty on transfer", int'(buf_empty), 1);
        run_bits(d, 1, req);
        tick(1'b0);
        chk("R9 done after last stop", int'(tx_done), 1);
        chk("R1 idle high", int'(tx_line), 1);
        clear_done();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R12 line high in reset", int'(tx_line), 1);
        chk("R12 done low in reset", int'(tx_done), 0);
        chk("R7 empty in reset", int'(buf_empty), 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12 line high after reset", int'(tx_line), 1);
        chk("R7 empty after reset", int'(buf_empty), 1);

        // R1 R2 R3 R4 R5 R6: sweep every width, parity mode and stop count
        for (int sz = 0; sz < 5; sz++) begin
            for (int pm = 0; pm < 3; pm++) begin
                for (int st = 0; st < 2; st++) begin
                    char_size = 3'(sz);
                    par_en    = (pm != 0);
                    par_odd   = (pm == 2);
                    two_stop  = st[0];
                    full_frame(9'h1FF, "R2 R5 R6 frame all ones");
                    full_frame((sz * 97 + pm * 31 + st * 13 + 5) & 9'h1FF, "R3 R4 R5 frame mixed");
                    full_frame(9'h100 | (sz * 7), "R3 R4 frame high bit");
                end
            end
        end

        // R8: back-to-back frames with no idle gap
        char_size = 3'd3; par_en = 1'b1; par_odd = 1'b0; two_stop = 1'b0;
        write_char(8'hA5);
        tick(1'b0);
        chk("R8 first start", int'(tx_line), 0);
        write_char(8'h3C);
        run_bits(8'hA5, 1, "R8 first frame");
        tick(1'b0);
        chk("R8 second start on closing tick", int'(tx_line), 0);
        chk("R8 done stays low", int'(tx_done), 0);
        chk("R8 buffer freed", int'(buf_empty), 1);
        run_bits(8'h3C, 1, "R8 second frame");
        tick(1'b0);
        chk("R9 done after pair", int'(tx_done), 1);
        clear_done();

        // R7: write while full is discarded
        write_char(8'h81);
        write_char(8'h7E);
        tick(1'b0);
        run_bits(8'h81, 1, "R7 kept char");
        tick(1'b0);
        chk("R7 discarded write not sent", int'(tx_line), 1);
        chk("R7 discarded write done", int'(tx_done), 1);
        tick(1'b0);
        chk("R7 line still idle", int'(tx_line), 1);
        clear_done();

        // R11: disabled transmitter holds line and buffer
        tx_en = 1'b0;
        write_char(8'h55);
        tick(1'b0); tick(1'b0); tick(1'b0);
        chk("R11 line high when disabled", int'(tx_line), 1);
        chk("R11 char stays buffered", int'(buf_empty), 0);
        tx_en = 1'b1;
        tick(1'b0);
        chk("R11 start after enable", int'(tx_line), 0);
        run_bits(8'h55, 1, "R11 frame after enable");

        // R9 same-cycle set and clear: set wins
        tick(1'b1);
        chk("R9 set beats clear", int'(tx_done), 1);

        // R10 interrupt gating
        chk("R10 done request off", int'(irq_done), 0);
        chk("R10 empty request off", int'(irq_empty), 0);
        @(negedge clk); ie_done = 1'b1; ie_empty = 1'b1;
        @(negedge clk);
        chk("R10 done request on", int'(irq_done), 1);
        chk("R10 empty request on", int'(irq_empty), 1);
        write_char(8'h0F);
        chk("R10 empty request drops when full", int'(irq_empty), 0);

        // R9 clear by acknowledge
        @(negedge clk); txc_ack = 1'b1;
        @(negedge clk); txc_ack = 1'b0;
        chk("R9 clear by acknowledge", int'(tx_done), 0);
        chk("R10 done request follows flag", int'(irq_done), 0);
        tick(1'b0);
        run_bits(8'h0F, 1, "R1 final frame");
        tick(1'b0);
        chk("R10 done request after frame", int'(irq_done), 1);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule